// File: doc/BRIEF.md
# Incrementing-Burst Re-arbitration Point Generator

This block sits beside the slave-side arbiter of a bus matrix and watches the address phase of one master's transfers. Whenever that master issues an incrementing burst of undefined length, the block tells the arbiter where the burst may be cut so that another master can be granted the slave. It does so with a single-cycle strobe, `rearb_ok`, raised in the cycle after the beat that closes a chunk.

How long a chunk may run is chosen per master by a 3-bit code held in a small register bank, one register per master. Code 0 never predicts an end. Code 1 makes every beat a chunk of its own. Codes 2 to 7 cut the burst into chunks of 2^code beats (4, 8, 16, 32, 64 or 128). Under every code a burst is also cut on the last beat before a 1-Kbyte address boundary. An external slot-limit indication forces a cut at any time. Fixed-length bursts are never cut by the policy. The master whose register applies is named by `mst_id`. The code is captured on each NONSEQ beat, so a register change takes effect at the start of the next burst. A global protect input blocks register writes.

Top module: `incr_burst_breaker`

## Requirements
- R1: Out of reset, every master register holds 0, every read returns 0 and `rearb_ok` is low.
- R2: Master register x sits at byte address 4*x for x = 0..12. A write with `cfg_wr_en` high stores `cfg_wfield[2:0]` there. A read returns that value in bits 2:0, and bits 31:3 read as zero. An address that is not a multiple of 4, or that is at or above 52, reads as 0 and is not written.
- R3: While `cfg_wprot` is 1, writes change no register.
- R4: With code 0, a completed INCR beat raises `rearb_ok` only through the boundary rule (R7) or the slot limit (R10).
- R5: With code 1, every completed INCR beat raises `rearb_ok` in the following cycle.
- R6: With code c from 2 to 7, `rearb_ok` rises in the cycle after the completed INCR beat that ends each run of 2^c beats. The count starts at the NONSEQ beat (which is beat 1) and restarts after each strobe.
- R7: Under any code, a completed INCR beat whose address plus 2^hsize is a multiple of 1024 raises `rearb_ok` in the following cycle and restarts the count.
- R8: A beat is counted only when `hready` is 1, `htrans` is NONSEQ (2) or SEQ (3) and `hburst` is INCR (1). IDLE (0), BUSY (1) and wait cycles are not counted. Bursts with any other `hburst` value never raise `rearb_ok` except through R10, and their NONSEQ beat clears the count.
- R9: The code is taken from the register of `mst_id` on each completed NONSEQ beat and held until the next one. A register write made during a burst does not alter that burst's chunking. An `mst_id` of 13 or above selects code 0.
- R10: `slot_limit_reached` high in a cycle raises `rearb_ok` in the next cycle and clears the count under any code. A beat completed in that same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write enable |
| cfg_addr | input | 6 | Register byte address, shared by read and write |
| cfg_wfield | input | 3 | Policy code to write |
| cfg_wprot | input | 1 | Global write protect, 1 blocks writes |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| mst_id | input | 4 | Master whose register applies to the next NONSEQ beat |
| htrans | input | 2 | Transfer type: IDLE 0, BUSY 1, NONSEQ 2, SEQ 3 |
| hburst | input | 3 | Burst type, INCR is 1 |
| haddr | input | 32 | Byte address of the current beat |
| hsize | input | 3 | Beat size, 2^hsize bytes |
| hready | input | 1 | Beat completes when high |
| slot_limit_reached | input | 1 | External slot-limit cut request |
| rearb_ok | output | 1 | One-cycle re-arbitration-allowed strobe |

## Verification
The bench sweeps every code over long byte bursts with wait states and BUSY cycles inserted at fixed intervals. A counter that ticked on a stalled or BUSY cycle would cut early and miscompare at the first chunk end. Bursts that start just below a 1-Kbyte line, at word, halfword and double-word sizes, catch an off-by-one boundary test. They also catch a chunk count that is not restarted after a boundary cut, which would shift every later cut. Register writes in mid-burst, and bursts from an out-of-range master number, catch a design that re-reads the code on every beat or indexes past the bank. Slot-limit pulses in unlimited and 8-beat bursts expose a count that is left uncleared. Sweeps over all addresses and the protect bit show writes that land where they must not.

// File: rtl/ulb_pkg.sv
package ulb_pkg;

   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } trans_e;

   localparam logic [2:0] BURST_INCR = 3'b001;

   localparam int CODE_UNLIMITED = 0;
   localparam int CODE_SINGLE    = 1;

endpackage

// File: rtl/ulb_cfg_bank.sv
module ulb_cfg_bank #(
   parameter int NUM_MST = 13,
   parameter int CODE_W  = 3,
   parameter int DATA_W  = 32,
   parameter int RAW     = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [RAW-1:0]            addr_i,
   input  logic [CODE_W-1:0]         wfield_i,
   input  logic                      wprot_i,
   output logic [DATA_W-1:0]         rdata_o,
   output logic [NUM_MST*CODE_W-1:0] codes_o
);
   localparam int IDX_W = RAW - 2;

   if (NUM_MST < 2) begin : g_chk_num
      $error("ulb_cfg_bank: NUM_MST must be at least 2");
   end
   if (NUM_MST * 4 > (1 << RAW)) begin : g_chk_raw
      $error("ulb_cfg_bank: RAW too small for the register count");
   end
   if (CODE_W >= DATA_W) begin : g_chk_code
      $error("ulb_cfg_bank: CODE_W must be narrower than DATA_W");
   end

   logic [IDX_W-1:0]  idx;
   logic              aligned;
   logic              in_range;
   logic              wr_ok;
   logic [CODE_W-1:0] codes_q [NUM_MST];

   assign idx      = addr_i[RAW-1:2];
   assign aligned  = (addr_i[1:0] == 2'b00);
   assign in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_MST));
   assign wr_ok    = wr_en_i && !wprot_i && aligned && in_range;

   for (genvar g = 0; g < NUM_MST; g++) begin : g_reg
      logic sel;
      assign sel = wr_ok && (idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            codes_q[g] <= '0;
         end else if (sel) begin
            codes_q[g] <= wfield_i;
         end
      end
      assign codes_o[g*CODE_W +: CODE_W] = codes_q[g];
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_MST; i++) begin
         if (aligned && in_range && (idx == IDX_W'(i))) begin
            rdata_o[CODE_W-1:0] = codes_q[i];
         end
      end
   end

   // R3: protect holds every register still
   p_protect_freeze_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      wprot_i |=> $stable(codes_o));

   // R2: bits above the field always read zero
   p_upper_zero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      rdata_o[DATA_W-1:CODE_W] == '0);

   // R2: a misaligned address leaves the bank untouched
   p_misaligned_ignored_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !aligned) |=> $stable(codes_o));

endmodule

// File: rtl/ulb_boundary_det.sv
module ulb_boundary_det #(
   parameter int ADDR_W  = 32,
   parameter int BND_LG2 = 10,
   parameter int SIZE_W  = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic              last_before_o
);
   localparam int MAX_BEAT_LG2 = (1 << SIZE_W) - 1;

   if (BND_LG2 >= ADDR_W) begin : g_chk_bnd
      $error("ulb_boundary_det: boundary must lie inside the address");
   end
   if (MAX_BEAT_LG2 > BND_LG2) begin : g_chk_beat
      $error("ulb_boundary_det: widest beat exceeds the boundary size");
   end

   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] nxt_addr;

   assign step          = ADDR_W'(1) << size_i;
   assign nxt_addr      = addr_i + step;
   // next beat sits in another line: the current beat is the last one before it
   assign last_before_o = |((nxt_addr ^ addr_i) >> BND_LG2);

endmodule

// File: rtl/ulb_chunk_ctrl.sv
module ulb_chunk_ctrl #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_any_i,
   input  logic              beat_start_i,
   input  logic              beat_incr_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              bnd_i,
   input  logic              slot_i,
   output logic              strobe_o
);
   localparam int CNT_W = 1 << CODE_W;

   if (CODE_W < 1 || CODE_W > 5) begin : g_chk_code
      $error("ulb_chunk_ctrl: CODE_W out of supported range");
   end

   function automatic logic [CNT_W-1:0] chunk_len(input logic [CODE_W-1:0] c);
      if (c == CODE_W'(ulb_pkg::CODE_SINGLE)) begin
         return CNT_W'(1);
      end
      return CNT_W'(1) << c;
   endfunction

   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] eff_code;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_inc;
   logic [CNT_W-1:0]  cnt_d;
   logic [CNT_W-1:0]  lim;
   logic              unlimited;
   logic              hit;
   logic              fire;
   logic              strobe_q;

   assign eff_code  = beat_start_i ? code_i : code_q;
   assign unlimited = (eff_code == CODE_W'(ulb_pkg::CODE_UNLIMITED));
   assign lim       = chunk_len(eff_code);

   always_comb begin
      if (unlimited) begin
         cnt_inc = '0;
      end else if (beat_start_i) begin
         cnt_inc = CNT_W'(1);
      end else begin
         cnt_inc = cnt_q + CNT_W'(1);
      end
   end

   assign hit  = beat_incr_i && (bnd_i || (!unlimited && (cnt_inc == lim)));
   assign fire = slot_i || hit;

   always_comb begin
      if (slot_i) begin
         cnt_d = '0;
      end else if (beat_incr_i) begin
         cnt_d = hit ? '0 : cnt_inc;
      end else if (beat_start_i) begin
         cnt_d = '0;
      end else begin
         cnt_d = cnt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q   <= '0;
         cnt_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         if (beat_start_i) begin
            code_q <= code_i;
         end
         cnt_q    <= cnt_d;
         strobe_q <= fire;
      end
   end

   assign strobe_o = strobe_q;

   // R10: slot limit always produces a strobe
   p_slot_forces_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      slot_i |=> strobe_o);

   // R10: slot limit leaves the count empty
   p_slot_clears_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      slot_i |=> (cnt_q == '0));

   // R5: single mode cuts after every counted beat
   p_single_each_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (beat_incr_i && (eff_code == CODE_W'(ulb_pkg::CODE_SINGLE))) |=> strobe_o);

   // R8: non-incrementing beats never cut on their own
   p_fixed_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (beat_any_i && !beat_incr_i && !slot_i) |=> !strobe_o);

   // R4: unlimited mode is quiet away from boundary and slot limit
   p_unlimited_quiet_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (beat_incr_i && unlimited && !bnd_i && !slot_i) |=> !strobe_o);

   // R6: the held count never reaches the chunk length
   p_cnt_below_limit_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (code_q != '0) |-> (cnt_q < chunk_len(code_q)));

   // R8: idle, busy and wait cycles leave the count alone
   p_no_beat_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_any_i && !slot_i) |=> $stable(cnt_q));

endmodule

// File: rtl/incr_burst_breaker.sv
module incr_burst_breaker #(
   parameter int NUM_MST = 13,
   parameter int CODE_W  = 3,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 32,
   parameter int SIZE_W  = 3,
   parameter int BND_LG2 = 10,
   localparam int RAW    = $clog2(NUM_MST * 4),
   localparam int MID_W  = $clog2(NUM_MST)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [RAW-1:0]    cfg_addr,
   input  logic [CODE_W-1:0] cfg_wfield,
   input  logic              cfg_wprot,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic [MID_W-1:0]  mst_id,
   input  logic [1:0]        htrans,
   input  logic [2:0]        hburst,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [SIZE_W-1:0] hsize,
   input  logic              hready,
   input  logic              slot_limit_reached,
   output logic              rearb_ok
);
   import ulb_pkg::*;

   logic [NUM_MST*CODE_W-1:0] codes;
   logic [CODE_W-1:0]         sel_code;
   logic                      beat_any;
   logic                      beat_start;
   logic                      beat_incr;
   logic                      bnd_last;

   ulb_cfg_bank #(
      .NUM_MST (NUM_MST),
      .CODE_W  (CODE_W),
      .DATA_W  (DATA_W),
      .RAW     (RAW)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (cfg_wr_en),
      .addr_i   (cfg_addr),
      .wfield_i (cfg_wfield),
      .wprot_i  (cfg_wprot),
      .rdata_o  (cfg_rdata),
      .codes_o  (codes)
   );

   always_comb begin
      sel_code = '0;
      for (int i = 0; i < NUM_MST; i++) begin
         if (mst_id == MID_W'(i)) begin
            sel_code = codes[i*CODE_W +: CODE_W];
         end
      end
   end

   assign beat_any   = hready && htrans[1];
   assign beat_start = beat_any && (htrans == TR_NONSEQ);
   assign beat_incr  = beat_any && (hburst == BURST_INCR);

   ulb_boundary_det #(
      .ADDR_W  (ADDR_W),
      .BND_LG2 (BND_LG2),
      .SIZE_W  (SIZE_W)
   ) u_bnd (
      .addr_i        (haddr),
      .size_i        (hsize),
      .last_before_o (bnd_last)
   );

   ulb_chunk_ctrl #(
      .CODE_W (CODE_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .beat_any_i   (beat_any),
      .beat_start_i (beat_start),
      .beat_incr_i  (beat_incr),
      .code_i       (sel_code),
      .bnd_i        (bnd_last),
      .slot_i       (slot_limit_reached),
      .strobe_o     (rearb_ok)
   );

   // R7: a counted beat that closes a 1-Kbyte line always cuts
   p_boundary_cut_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (beat_incr && bnd_last) |=> rearb_ok);

   // R1: no strobe without a beat or a slot request the cycle before
   p_strobe_has_cause_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_incr && !slot_limit_reached) |=> !rearb_ok);

endmodule

// File: tb/sim_incr_burst_breaker.sv
module sim_incr_burst_breaker;

   logic        clk;
   logic        rst_n;
   logic        cfg_wr_en;
   logic [5:0]  cfg_addr;
   logic [2:0]  cfg_wfield;
   logic        cfg_wprot;
   logic [31:0] cfg_rdata;
   logic [3:0]  mst_id;
   logic [1:0]  htrans;
   logic [2:0]  hburst;
   logic [31:0] haddr;
   logic [2:0]  hsize;
   logic        hready;
   logic        slot_limit_reached;
   logic        rearb_ok;

   incr_burst_breaker u0 (
      .clk                (clk),
      .rst_n              (rst_n),
      .cfg_wr_en          (cfg_wr_en),
      .cfg_addr           (cfg_addr),
      .cfg_wfield         (cfg_wfield),
      .cfg_wprot          (cfg_wprot),
      .cfg_rdata          (cfg_rdata),
      .mst_id             (mst_id),
      .htrans             (htrans),
      .hburst             (hburst),
      .haddr              (haddr),
      .hsize              (hsize),
      .hready             (hready),
      .slot_limit_reached (slot_limit_reached),
      .rearb_ok           (rearb_ok)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   int    regs_m [16];
   int    m_code = 0;
   int    m_cnt  = 0;
   bit    exp_q  = 0;
   string exp_tag = "R1";
   int    cyc = 0;

   bit        cw_en   = 0;
   int        cw_addr = 0;
   int        cw_val  = 0;

   task automatic check_bit(input bit got, input bit want, input string tag);
      vectors++;
      if (got !== want) begin
         fails++;
         $display("FAIL %s rearb_ok got %0b expected %0b at %0t", tag, got, want, $time);
      end
   endtask

   task automatic check_rd(input int addr, input int want, input string tag);
      @(negedge clk);
      cfg_wr_en = 1'b0;
      cfg_addr  = 6'(addr);
      #1;
      vectors++;
      if (cfg_rdata !== 32'(want)) begin
         fails++;
         $display("FAIL %s read addr %0d got %0h expected %0h", tag, addr, cfg_rdata, want);
      end
   endtask

   task automatic step(input logic [1:0] tr, input logic [2:0] hb, input int ad,
                       input int sz, input bit rd, input bit sl, input string tag);
      bit beat;
      bit ns;
      bit bnd;
      int lim;
      int nc;
      @(negedge clk);
      check_bit(rearb_ok, exp_q, exp_tag);
      htrans             = tr;
      hburst             = hb;
      haddr              = 32'(ad);
      hsize              = 3'(sz);
      hready             = rd;
      slot_limit_reached = sl;
      cfg_wr_en          = cw_en;
      cfg_addr           = 6'(cw_addr);
      cfg_wfield         = 3'(cw_val);
      beat = rd && tr[1];
      ns   = beat && (tr == 2'b10);
      if (ns) m_code = (int'(mst_id) < 13) ? regs_m[mst_id] : 0;
      exp_q = 0;
      if (sl) begin
         exp_q = 1;
         m_cnt = 0;
      end else if (beat && hb == 3'b001) begin
         lim = (m_code == 1) ? 1 : (1 << m_code);
         nc  = (m_code == 0) ? 0 : (ns ? 1 : m_cnt + 1);
         bnd = ((ad & 1023) + (1 << sz)) >= 1024;
         exp_q = bnd || (m_code != 0 && nc == lim);
         m_cnt = exp_q ? 0 : nc;
      end else if (ns) begin
         m_cnt = 0;
      end
      if (cw_en && !cfg_wprot && (cw_addr % 4 == 0) && (cw_addr / 4 < 13))
         regs_m[cw_addr / 4] = cw_val & 7;
      exp_tag = tag;
      cw_en = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(2'b00, 3'b001, 0, 0, 1, 0, "R8");
   endtask

   task automatic cfg_write(input int addr, input int val, input string tag);
      cw_en   = 1;
      cw_addr = addr;
      cw_val  = val;
      step(2'b00, 3'b001, 0, 0, 1, 0, tag);
   endtask

   // drives one burst, with wait and BUSY cycles at fixed intervals
   task automatic burst(input int mst, input logic [2:0] hb, input int start, input int sz,
                        input int n, input int slot_at, input int wr_at, input int wr_val,
                        input string tag);
      int  b = 0;
      int  ad = start;
      bit  slot_done = 0;
      bit  wr_done = 0;
      bit  sl;
      mst_id = 4'(mst);
      while (b < n) begin
         cyc++;
         sl = 0;
         if (b == slot_at && !slot_done) begin
            sl = 1;
            slot_done = 1;
         end
         if (b == wr_at && !wr_done) begin
            cw_en   = 1;
            cw_addr = mst * 4;
            cw_val  = wr_val;
            wr_done = 1;
         end
         if (b > 0 && (cyc % 11) == 10) begin
            step(2'b01, hb, ad, sz, 1, sl, tag);
         end else if ((cyc % 7) == 6) begin
            step((b == 0) ? 2'b10 : 2'b11, hb, ad, sz, 0, sl, tag);
         end else begin
            step((b == 0) ? 2'b10 : 2'b11, hb, ad, sz, 1, sl, tag);
            b++;
            ad = ad + (1 << sz);
         end
      end
      idle(2);
   endtask

   initial begin
      rst_n = 1'b0;
      cfg_wr_en = 0; cfg_addr = 0; cfg_wfield = 0; cfg_wprot = 0;
      mst_id = 0; htrans = 0; hburst = 0; haddr = 0; hsize = 0; hready = 1;
      slot_limit_reached = 0;
      for (int i = 0; i < 16; i++) regs_m[i] = 0;

      // R1: reset state
      repeat (3) @(negedge clk);
      check_bit(rearb_ok, 1'b0, "R1");
      rst_n = 1'b1;
      for (int x = 0; x < 13; x++) check_rd(x * 4, 0, "R1");
      idle(2);

      // R2: each register, each aligned and stray address
      for (int x = 0; x < 13; x++) cfg_write(x * 4, (x * 3 + 5) & 7, "R2");
      idle(1);
      for (int a = 0; a < 64; a++)
         check_rd(a, ((a % 4 == 0) && (a / 4 < 13)) ? ((a / 4 * 3 + 5) & 7) : 0, "R2");
      cfg_write(6, 7, "R2");
      cfg_write(52, 7, "R2");
      cfg_write(60, 7, "R2");
      idle(1);
      for (int x = 0; x < 13; x++) check_rd(x * 4, (x * 3 + 5) & 7, "R2");

      // R3: protect blocks every write
      cfg_wprot = 1;
      for (int x = 0; x < 13; x++) cfg_write(x * 4, ~(x * 3 + 5) & 7, "R3");
      idle(1);
      for (int x = 0; x < 13; x++) check_rd(x * 4, (x * 3 + 5) & 7, "R3");
      cfg_wprot = 0;

      // program master m with code m for the sweep
      for (int x = 0; x < 13; x++) cfg_write(x * 4, x & 7, "R2");
      idle(1);
      for (int x = 0; x < 8; x++) check_rd(x * 4, x, "R2");

      // R4 R5 R6: sweep codes over byte bursts away from any boundary
      burst(0, 3'b001, 0, 0, 300, -1, -1, 0, "R4");
      burst(1, 3'b001, 0, 0, 40, -1, -1, 0, "R5");
      for (int c = 2; c < 8; c++) burst(c, 3'b001, 0, 0, 300, -1, -1, 0, "R6");
      // back-to-back bursts restart the count at NONSEQ
      burst(2, 3'b001, 0, 0, 3, -1, -1, 0, "R6");
      burst(2, 3'b001, 16, 0, 6, -1, -1, 0, "R6");

      // R7: boundary under several sizes and codes
      burst(0, 3'b001, 0, 2, 300, -1, -1, 0, "R7");
      burst(3, 3'b001, 32'h3F0, 1, 20, -1, -1, 0, "R7");
      burst(2, 3'b001, 32'h7C8, 3, 20, -1, -1, 0, "R7");
      burst(5, 3'b001, 32'h1FFA, 1, 12, -1, -1, 0, "R7");

      // R8: fixed-length bursts never cut
      burst(1, 3'b011, 0, 2, 4, -1, -1, 0, "R8");
      burst(1, 3'b101, 32'h3F0, 2, 8, -1, -1, 0, "R8");
      burst(1, 3'b000, 32'h3FC, 2, 1, -1, -1, 0, "R8");
      burst(1, 3'b111, 0, 2, 16, -1, -1, 0, "R8");

      // R9: mid-burst write does not alter the running burst
      burst(4, 3'b001, 0, 0, 40, -1, 5, 1, "R9");
      check_rd(16, 1, "R9");
      burst(4, 3'b001, 0, 0, 6, -1, -1, 0, "R9");
      cfg_write(48, 2, "R9");
      burst(12, 3'b001, 0, 0, 10, -1, -1, 0, "R9");
      burst(13, 3'b001, 0, 0, 20, -1, -1, 0, "R9");
      burst(15, 3'b001, 0, 0, 20, -1, -1, 0, "R9");

      // R10: slot limit in unlimited and 8-beat bursts
      burst(0, 3'b001, 0, 0, 50, 20, -1, 0, "R10");
      burst(3, 3'b001, 0, 0, 30, 5, -1, 0, "R10");
      burst(1, 3'b011, 0, 2, 4, 2, -1, 0, "R10");
      burst(7, 3'b001, 0, 0, 10, 0, -1, 0, "R10");
      idle(3);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule